// File: doc/BRIEF.md
# Programmable Burst Column Sequencer

This block produces the column address stream for a memory read or write burst. Its settings come from a small mode register. That register is written from the address bus when the mode load strobe is high. The settings are the read latency, the burst length, the wrap order and a single-access option for writes. When a read or write command arrives with a start column, the block presents one column per clock. It marks each beat as valid and flags the final beat.

A new command may arrive on any clock. It drops the burst in progress and starts again from the new column. A stop strobe ends a burst early, including a full-row burst that would otherwise run without end. A separate output gives the read data-valid timing: it is the stream of read beats delayed so that the first beat's data is valid the programmed latency after the command. Array access and data-path timing are left to the surrounding logic.

Top module: `burst_col_seq`

## Requirements
- R1: While reset is low, and until the first command, `col_valid_o`, `col_last_o`, `col_wr_o` and `rd_valid_o` are low. The reset mode is length 1, sequential order, latency 2 and writes that burst.
- R2: A clock edge with `mode_load_i` high stores `mode_i`, which has four fields:
  - bits [2:0] select the burst length: 0 gives 1, 1 gives 2, 2 gives 4, 3 gives 8, 7 gives a full row, and 4 to 6 give 1.
  - bit 3 selects the order: 0 is sequential, 1 is interleaved.
  - bits [6:4] give the latency: 2 or 3, and any other value acts as 2.
  - bit 9 set makes writes single-access.
- R3: A clock edge with `rd_i` or `wr_i` high starts a burst. In the following cycle `col_valid_o` is high and `col_o` equals the low COL_BITS bits of `col_i`. `col_wr_o` is high for a write.
- R4: In sequential order with length L, beat k presents the start column with its low log2(L) bits replaced by (start + k) mod L. The count wraps inside the aligned block.
- R5: In interleaved order with length L, beat k presents the start column XOR k.
- R6: `col_last_o` is high exactly on beat L-1. In the cycle after the last beat, `col_valid_o` is low unless a new command was taken.
- R7: A full-row burst presents (start + k) mod 2^COL_BITS whatever order is set. It never raises `col_last_o`, and it runs until a stop or a new command.
- R8: With single-access writes set, a write burst has length 1. A read still uses the programmed length.
- R9: A command on any clock replaces the burst in progress. A command wins over `stop_i` on the same edge. `rd_i` and `wr_i` high together count as a read.
- R10: `stop_i` high at an edge with no command makes `col_valid_o` low in the next cycle.
- R11: For a read beat presented in the cycle after edge n, `rd_valid_o` is high in the cycle after edge n+CL-1, where CL is the latency in force. Write beats never raise `rd_valid_o`.
- R12: A burst latches its length and order when it starts. A mode load during a burst does not change that burst.
- R13: The bits of `col_o` at and above COL_BITS are always zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_load_i | input | 1 | Store `mode_i` into the mode register |
| mode_i | input | 10 | Mode word taken from the address bus |
| rd_i | input | 1 | Read command |
| wr_i | input | 1 | Write command |
| stop_i | input | 1 | End the current burst |
| col_i | input | COL_W | Start column for a command |
| col_o | output | COL_W | Column of the current beat |
| col_valid_o | output | 1 | A beat is presented this cycle |
| col_last_o | output | 1 | The beat is the burst's final one |
| col_wr_o | output | 1 | The current burst is a write |
| rd_valid_o | output | 1 | Read data valid, delayed by the latency |

## Verification
The bench runs a reduced 8-bit column space. It sweeps every fixed length in both orders over many start columns, both aligned and unaligned, and alternates latency and direction. Unaligned starts separate block-wrapping sequential order from plain counting, and they separate interleaved order from sequential order. Latency is checked beat by beat through the delayed read-valid output. Targeted sequences then cover the remaining cases:
- a full row that wraps past the top column, then is stopped;
- an interrupt part-way through a burst;
- a command and a stop on the same edge;
- a mode load during a burst;
- single-access writes, against reads that still burst;
- reserved length and latency codes;
- a start column with bits above the column space set.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;
  localparam int MODE_W = 10;
  localparam int BL_LSB = 0;
  localparam int ILV_BIT = 3;
  localparam int LAT_LSB = 4;
  localparam int WSGL_BIT = 9;

  localparam logic [2:0] BL_CODE_PAGE = 3'd7;
endpackage

// File: rtl/bsq_mode_reg.sv
module bsq_mode_reg
  import burst_seq_pkg::*;
#(
  parameter int COL_BITS = 10,
  parameter int MAX_CL   = 3,
  localparam int LAT_W   = $clog2(MAX_CL + 1)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                load_i,
  input  logic [MODE_W-1:0]   mode_i,
  output logic [COL_BITS-1:0] len_mask_o,
  output logic                full_o,
  output logic                ilv_o,
  output logic                wr_single_o,
  output logic [LAT_W-1:0]    lat_o
);
  logic [2:0] bl_q;
  logic [2:0] lat_q;
  logic       ilv_q;
  logic       wsgl_q;
  logic [1:0] unused_mode;

  assign unused_mode = mode_i[8:7];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bl_q   <= 3'd0;
      lat_q  <= 3'd2;
      ilv_q  <= 1'b0;
      wsgl_q <= 1'b0;
    end else if (load_i) begin
      bl_q   <= mode_i[BL_LSB +: 3];
      lat_q  <= mode_i[LAT_LSB +: 3];
      ilv_q  <= mode_i[ILV_BIT];
      wsgl_q <= mode_i[WSGL_BIT];
    end
  end

  always_comb begin
    full_o = (bl_q == BL_CODE_PAGE);
    unique case (bl_q)
      3'd1:    len_mask_o = COL_BITS'(1);
      3'd2:    len_mask_o = COL_BITS'(3);
      3'd3:    len_mask_o = COL_BITS'(7);
      3'd7:    len_mask_o = '1;
      default: len_mask_o = '0;
    endcase
  end

  assign ilv_o       = ilv_q;
  assign wr_single_o = wsgl_q;
  assign lat_o = (lat_q >= 3'd2 && int'(lat_q) <= MAX_CL) ? LAT_W'(lat_q) : LAT_W'(2);

  a_r2_lat_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (int'(lat_o) >= 2) && (int'(lat_o) <= MAX_CL));
endmodule

// File: rtl/bsq_col_gen.sv
module bsq_col_gen #(
  parameter int COL_W    = 10,
  parameter int COL_BITS = 10
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                cmd_i,
  input  logic                is_wr_i,
  input  logic                stop_i,
  input  logic [COL_W-1:0]    col_i,
  input  logic [COL_BITS-1:0] len_mask_i,
  input  logic                full_i,
  input  logic                ilv_i,
  input  logic                wr_single_i,
  output logic [COL_W-1:0]    col_o,
  output logic                valid_o,
  output logic                last_o,
  output logic                wr_o
);
  logic                act_q, wr_q, full_q, ilv_q;
  logic [COL_BITS-1:0] start_q, beat_q, mask_q;
  logic [COL_BITS-1:0] seq_col, ilv_col, cur_col, start_d;
  logic                single_d;

  assign start_d  = col_i[COL_BITS-1:0];
  assign single_d = is_wr_i && wr_single_i;

  always_comb begin
    seq_col = (start_q & ~mask_q) | ((start_q + beat_q) & mask_q);
    ilv_col = start_q ^ beat_q;
    cur_col = (ilv_q && !full_q) ? ilv_col : seq_col;
  end

  assign col_o   = COL_W'(cur_col);
  assign valid_o = act_q;
  assign last_o  = act_q && !full_q && (beat_q == mask_q);
  assign wr_o    = act_q && wr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q   <= 1'b0;
      wr_q    <= 1'b0;
      full_q  <= 1'b0;
      ilv_q   <= 1'b0;
      start_q <= '0;
      beat_q  <= '0;
      mask_q  <= '0;
    end else if (cmd_i) begin
      act_q   <= 1'b1;
      wr_q    <= is_wr_i;
      start_q <= start_d;
      beat_q  <= '0;
      ilv_q   <= ilv_i;
      full_q  <= full_i && !single_d;
      mask_q  <= single_d ? '0 : len_mask_i;
    end else if (stop_i) begin
      act_q <= 1'b0;
    end else if (act_q) begin
      if (last_o) act_q <= 1'b0;
      else        beat_q <= beat_q + 1'b1;
    end
  end

  a_r3_start_col: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_i |=> valid_o && (col_o == COL_W'($past(start_d))));
  a_r6_last_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last_o |-> valid_o);
  a_r6_last_ends: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last_o && !cmd_i && !stop_i |=> !valid_o);
  a_r10_stop_ends: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i && !cmd_i |=> !valid_o);
  a_r8_single_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_i && is_wr_i && wr_single_i |=> last_o && wr_o);
  a_r13_upper_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (col_o >> COL_BITS) == '0);
endmodule

// File: rtl/bsq_lat_pipe.sv
module bsq_lat_pipe #(
  parameter int MAX_CL  = 3,
  localparam int LAT_W  = $clog2(MAX_CL + 1),
  localparam int DEPTH  = MAX_CL - 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             beat_i,
  input  logic [LAT_W-1:0] lat_i,
  output logic             rd_valid_o
);
  logic [DEPTH-1:0] sr_q;

  for (genvar g = 0; g < DEPTH; g++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) sr_q[g] <= 1'b0;
      else if (g == 0) sr_q[g] <= beat_i;
      else sr_q[g] <= sr_q[(g > 0) ? g - 1 : 0];
    end
  end

  always_comb begin
    rd_valid_o = 1'b0;
    for (int i = 0; i < DEPTH; i++)
      if (lat_i == LAT_W'(i + 2)) rd_valid_o = sr_q[i];
  end

  a_r11_cl2_delay: assert property (@(posedge clk_i) disable iff (!rst_ni)
    beat_i && lat_i == LAT_W'(2) |=> ($stable(lat_i) |-> rd_valid_o));
endmodule

// File: rtl/burst_col_seq.sv
module burst_col_seq
  import burst_seq_pkg::*;
#(
  parameter int COL_W    = 10,
  parameter int COL_BITS = 10,
  parameter int MAX_CL   = 3,
  localparam int LAT_W   = $clog2(MAX_CL + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mode_load_i,
  input  logic [MODE_W-1:0] mode_i,
  input  logic              rd_i,
  input  logic              wr_i,
  input  logic              stop_i,
  input  logic [COL_W-1:0]  col_i,
  output logic [COL_W-1:0]  col_o,
  output logic              col_valid_o,
  output logic              col_last_o,
  output logic              col_wr_o,
  output logic              rd_valid_o
);
  logic [COL_BITS-1:0] len_mask;
  logic                full, ilv, wr_single;
  logic [LAT_W-1:0]    lat;
  logic                cmd, is_wr;

  assign cmd   = rd_i || wr_i;
  assign is_wr = wr_i && !rd_i;

  bsq_mode_reg #(.COL_BITS(COL_BITS), .MAX_CL(MAX_CL)) u_mode (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (mode_load_i),
    .mode_i     (mode_i),
    .len_mask_o (len_mask),
    .full_o     (full),
    .ilv_o      (ilv),
    .wr_single_o(wr_single),
    .lat_o      (lat)
  );

  bsq_col_gen #(.COL_W(COL_W), .COL_BITS(COL_BITS)) u_gen (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cmd_i      (cmd),
    .is_wr_i    (is_wr),
    .stop_i     (stop_i),
    .col_i      (col_i),
    .len_mask_i (len_mask),
    .full_i     (full),
    .ilv_i      (ilv),
    .wr_single_i(wr_single),
    .col_o      (col_o),
    .valid_o    (col_valid_o),
    .last_o     (col_last_o),
    .wr_o       (col_wr_o)
  );

  bsq_lat_pipe #(.MAX_CL(MAX_CL)) u_lat (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .beat_i    (col_valid_o && !col_wr_o),
    .lat_i     (lat),
    .rd_valid_o(rd_valid_o)
  );

  a_r11_no_write_data: assert property (@(posedge clk_i) disable iff (!rst_ni)
    col_valid_o && col_wr_o && $past(!col_valid_o || col_wr_o) |=> !u_lat.sr_q[0]);
endmodule

// File: tb/burst_col_seq_bench.sv
`timescale 1ns/1ps
module burst_col_seq_bench;
  localparam int COL_W = 10;
  localparam int COL_BITS = 8;
  localparam int PAGE = 1 << COL_BITS;

  logic clk = 1'b0, rst_n = 1'b0;
  logic mode_load = 1'b0, rd = 1'b0, wr = 1'b0, stop = 1'b0;
  logic [9:0] mode = '0;
  logic [COL_W-1:0] col_in = '0;
  logic [COL_W-1:0] col;
  logic valid, last, cwr, rdv;
  int total = 0, bad = 0;

  always #2.5 clk = ~clk;

  burst_col_seq #(.COL_W(COL_W), .COL_BITS(COL_BITS), .MAX_CL(3)) u_burst_col_seq (
    .clk_i(clk), .rst_ni(rst_n), .mode_load_i(mode_load), .mode_i(mode),
    .rd_i(rd), .wr_i(wr), .stop_i(stop), .col_i(col_in),
    .col_o(col), .col_valid_o(valid), .col_last_o(last), .col_wr_o(cwr),
    .rd_valid_o(rdv)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [9:0] mk(input int blc, input int ilv, input int lat, input int sgl);
    return {sgl[0], 2'b00, lat[2:0], ilv[0], blc[2:0]};
  endfunction

  function automatic int exp_col(input int s, input int k, input int len, input int ilv);
    if (ilv != 0) return (s ^ k) % PAGE;
    return (s & ~(len - 1)) | ((s + k) & (len - 1));
  endfunction

  task automatic load(input logic [9:0] m);
    @(negedge clk); mode_load = 1'b1; mode = m;
    @(negedge clk); mode_load = 1'b0;
  endtask

  // cmd 0 = write, 1 = read, 2 = both strobes
  task automatic burst(input int cmd, input int s, input int len, input int ilv,
                       input int cl, input string tag);
    int lim;
    @(negedge clk); rd = (cmd != 0); wr = (cmd != 1); col_in = COL_W'(s);
    @(negedge clk); rd = 1'b0; wr = 1'b0;
    lim = len + cl + 1;
    for (int idx = 1; idx <= lim; idx++) begin
      if (idx <= len) begin
        chk(col == COL_W'(exp_col(s % PAGE, idx - 1, len, ilv)), tag, col,
            exp_col(s % PAGE, idx - 1, len, ilv));
        chk(valid === 1'b1, tag, valid, 1);
        chk(last === (idx == len), {tag, " R6 last"}, last, idx == len);
        chk(cwr === (cmd == 0), {tag, " R3 wr"}, cwr, cmd == 0);
      end else begin
        chk(valid === 1'b0, {tag, " R6 end"}, valid, 0);
      end
      chk(rdv === (cmd != 0 && idx >= cl && idx < cl + len), {tag, " R11 rd_valid"},
          rdv, cmd != 0 && idx >= cl && idx < cl + len);
      @(negedge clk);
    end
  endtask

  initial begin
    #(5.0 * 200000);
    bad++;
    $display("FAIL watchdog act=0 exp=1");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    // R1 reset state
    repeat (3) @(negedge clk);
    chk(!valid && !last && !cwr && !rdv, "R1 in reset", {valid, last, cwr, rdv}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(!valid && !last && !cwr && !rdv, "R1 after reset", {valid, last, cwr, rdv}, 0);
    // R1 reset mode: length 1, latency 2
    burst(1, 9, 1, 0, 2, "R1 default mode");

    // R2 R4 R5 sweep of lengths, orders, starts
    for (int ilv = 0; ilv < 2; ilv++)
      for (int blc = 0; blc < 4; blc++)
        for (int s = 0; s < PAGE; s += 7) begin
          int cl;
          cl = 2 + (s & 1);
          load(mk(blc, ilv, cl, 0));
          burst((s >> 1) & 1, s, 1 << blc, ilv, cl, ilv ? "R5 ilv" : "R4 seq");
        end

    // R2 reserved codes: length 5 -> 1, latency 6 -> 2
    load(mk(5, 0, 6, 0));
    burst(1, 33, 1, 0, 2, "R2 reserved codes");

    // R8 single write vs reads
    load(mk(3, 0, 3, 1));
    burst(0, 13, 1, 0, 3, "R8 single write");
    burst(1, 13, 8, 0, 3, "R8 read bursts");
    // R9 both strobes count as read
    burst(2, 21, 8, 0, 3, "R9 both strobes");

    // R13 upper bits of start column ignored
    load(mk(2, 0, 2, 0));
    burst(1, 10'h3FE, 4, 0, 2, "R13 upper bits");
    chk(1'b1, "R13", 0, 0);

    // R7 full row, interleave ignored, wraps, then stop (R10)
    load(mk(7, 1, 2, 0));
    @(negedge clk); rd = 1'b1; col_in = COL_W'(250);
    @(negedge clk); rd = 1'b0;
    for (int k = 0; k < PAGE + 4; k++) begin
      chk(valid && !last && col == COL_W'((250 + k) % PAGE), "R7 full row", col, (250 + k) % PAGE);
      @(negedge clk);
    end
    stop = 1'b1;
    @(negedge clk); stop = 1'b0;
    chk(valid === 1'b0, "R10 stop", valid, 0);

    // R9 interrupt mid burst
    load(mk(3, 0, 2, 0));
    @(negedge clk); rd = 1'b1; col_in = 10'd3;
    @(negedge clk); rd = 1'b0;
    for (int k = 0; k < 3; k++) begin
      chk(col == COL_W'(exp_col(3, k, 8, 0)), "R9 pre", col, exp_col(3, k, 8, 0));
      if (k < 2) @(negedge clk);
    end
    wr = 1'b1; col_in = 10'd42;
    @(negedge clk); wr = 1'b0;
    for (int k = 0; k < 8; k++) begin
      chk(valid && cwr && col == COL_W'(exp_col(42, k, 8, 0)) && last == (k == 7),
          "R9 restart", col, exp_col(42, k, 8, 0));
      @(negedge clk);
    end
    chk(valid === 1'b0, "R9 restart end", valid, 0);

    // R9 command wins over stop
    @(negedge clk); rd = 1'b1; stop = 1'b1; col_in = 10'd17;
    @(negedge clk); rd = 1'b0; stop = 1'b0;
    chk(valid && col == 10'd17, "R9 cmd over stop", col, 17);
    stop = 1'b1;
    @(negedge clk); stop = 1'b0;
    chk(valid === 1'b0, "R10 stop mid burst", valid, 0);

    // R12 mode load during a burst leaves it unchanged
    @(negedge clk); rd = 1'b1; col_in = 10'd64;
    @(negedge clk); rd = 1'b0;
    for (int k = 0; k < 8; k++) begin
      mode_load = (k == 1); mode = mk(1, 1, 2, 0);
      chk(valid && col == COL_W'(64 + k) && last == (k == 7), "R12 mid-burst load", col, 64 + k);
      @(negedge clk);
    end
    mode_load = 1'b0;
    chk(valid === 1'b0, "R12 end", valid, 0);
    burst(1, 65, 2, 1, 2, "R12 new mode applies");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule